// File: doc/BRIEF.md
# Successive-Approximation Register Datapath

This block holds the registers of a successive-approximation converter. One register keeps the bits confirmed so far, and a second register holds a single trial bit that walks from the most significant position towards the least significant. The code sent to the external DAC and comparator is the OR of these two registers. Setting a trial bit and later keeping or dropping it therefore needs no multiplexer and no clearing gates. A bit is dropped simply by not capturing the trial code.

An external sequencer drives three strobes. Shift moves the trial bit one place down. Accept captures the current trial code into the confirmed-bits register. Load copies the confirmed bits into a result register and re-arms the datapath for the next conversion. The block raises done once the trial bit has moved out past the least significant position. The result register keeps its value while the next conversion runs.

Top module: `sar_datapath`

## Requirements
- R1: While reset (active-low, asynchronous) is held, the confirmed bits are all zero and the trial bit sits in the MSB. The trial code therefore reads 1000 (decimal 8 at width 4), result reads 0 and done reads 0.
- R2: The trial code equals the confirmed-bits register ORed with the trial-bit register, bit by bit.
- R3: Each shift strobe moves the trial bit one position towards the LSB. After WIDTH shifts the trial-bit register is all zero, and further shifts leave it at zero.
- R4: When accept is high, the trial code is captured into the confirmed-bits register on the clock edge. When accept is low, that register keeps its value.
- R5: Shift and accept high in the same cycle both take effect. The captured value is the trial code from before the shift.
- R6: Done is high exactly when the trial-bit register is all zero.
- R7: A load strobe copies the confirmed bits into the result register, clears the confirmed bits and puts the trial bit back in the MSB. While load is high, shift and accept have no effect.
- R8: The result register changes only on a load strobe. It holds its value throughout the following conversion.
- R9: When accept follows an ideal comparator (keep the bit when the trial code is not above the input), one shift per cycle for WIDTH cycles and then a load leave the input code in the result register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shift_i | input | 1 | Move the trial bit one place towards the LSB |
| accept_i | input | 1 | Capture the trial code into the confirmed bits |
| load_i | input | 1 | Copy confirmed bits to result and re-arm |
| trial_o | output | WIDTH | Trial code to the DAC/comparator |
| result_o | output | WIDTH | Result of the last completed conversion |
| done_o | output | 1 | Trial bit exhausted |

## Verification
The bench builds the block at its default width of 4. At that width every possible input code, 0 through 15, can be converted exhaustively with an ideal comparator model. Directed steps also cover the edge orderings: accept alone, shift alone, shift together with accept, shifts after the trial bit is exhausted, and a load that arrives together with both other strobes. A behavioural model is compared against trial code, done and result on every clock.

// File: rtl/sar_pkg.sv
package sar_pkg;

    parameter int SAR_W = 4;

    typedef struct packed {
        logic load;
        logic accept;
        logic shift;
    } sar_strobe_t;

endpackage

// File: rtl/sar_mask_unit.sv
module sar_mask_unit
    import sar_pkg::*;
#(
    parameter int WIDTH = SAR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sar_strobe_t      strb,
    output logic [WIDTH-1:0] mask_q
);
    localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

    typedef struct packed {
        logic [WIDTH-1:0] mask;
    } mask_state_t;

    mask_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (strb.load) begin
            st_d.mask = MSB_ONLY;
        end else if (strb.shift) begin
            st_d.mask = st_q.mask >> 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask <= MSB_ONLY;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_q = st_q.mask;
endmodule

// File: rtl/sar_accept_unit.sv
module sar_accept_unit
    import sar_pkg::*;
#(
    parameter int WIDTH = SAR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sar_strobe_t      strb,
    input  logic [WIDTH-1:0] trial,
    output logic [WIDTH-1:0] acc_q
);
    typedef struct packed {
        logic [WIDTH-1:0] acc;
    } acc_state_t;

    acc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (strb.load) begin
            st_d.acc = '0;
        end else if (strb.accept) begin
            st_d.acc = trial;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.acc <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_q = st_q.acc;
endmodule

// File: rtl/sar_result_unit.sv
module sar_result_unit
    import sar_pkg::*;
#(
    parameter int WIDTH = SAR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sar_strobe_t      strb,
    input  logic [WIDTH-1:0] acc,
    output logic [WIDTH-1:0] res_q
);
    typedef struct packed {
        logic [WIDTH-1:0] res;
    } res_state_t;

    res_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (strb.load) begin
            st_d.res = acc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.res <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_q = st_q.res;
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
    import sar_pkg::*;
#(
    parameter int WIDTH = SAR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_i,
    input  logic             accept_i,
    input  logic             load_i,
    output logic [WIDTH-1:0] trial_o,
    output logic [WIDTH-1:0] result_o,
    output logic             done_o
);
    sar_strobe_t      strb;
    logic [WIDTH-1:0] mask_q;
    logic [WIDTH-1:0] acc_q;
    logic [WIDTH-1:0] trial;

    assign strb.load   = load_i;
    assign strb.accept = accept_i;
    assign strb.shift  = shift_i;

    // Trial code: confirmed bits plus the one bit under test.
    assign trial = acc_q | mask_q;

    sar_mask_unit #(.WIDTH(WIDTH)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .strb   (strb),
        .mask_q (mask_q)
    );

    sar_accept_unit #(.WIDTH(WIDTH)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .strb   (strb),
        .trial  (trial),
        .acc_q  (acc_q)
    );

    sar_result_unit #(.WIDTH(WIDTH)) u_res (
        .clk    (clk),
        .rst_n  (rst_n),
        .strb   (strb),
        .acc    (acc_q),
        .res_q  (result_o)
    );

    assign trial_o = trial;
    assign done_o  = ~|mask_q;
endmodule

// File: rtl/sar_datapath_checker.sv
module sar_datapath_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             shift_i,
    input logic             accept_i,
    input logic             load_i,
    input logic [WIDTH-1:0] trial_o,
    input logic [WIDTH-1:0] result_o,
    input logic             done_o,
    input logic [WIDTH-1:0] acc_q,
    input logic [WIDTH-1:0] mask_q
);
    localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

    // R2: trial differs from confirmed bits in at most one bit, and covers them
    p_trial_cover_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(trial_o ^ acc_q) <= 1) && ((trial_o & acc_q) == acc_q));

    // R3: trial bit is never more than one bit
    p_mask_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mask_q));

    // R3, R5: shift moves the trial bit down one place
    p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i) |=> (mask_q == ($past(mask_q) >> 1)));

    // R4, R5: accept captures the pre-edge trial code
    p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && !load_i) |=> (acc_q == $past(trial_o)));

    // R4: without accept or load the confirmed bits hold
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept_i && !load_i) |=> $stable(acc_q));

    // R6: when done, the trial code carries no test bit
    p_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (trial_o == acc_q));

    // R7: load transfers and re-arms
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> ((result_o == $past(acc_q)) && (acc_q == '0) && (mask_q == MSB_ONLY)));

    // R8: result holds without load
    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(result_o));
endmodule

bind sar_datapath sar_datapath_checker #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_i  (shift_i),
    .accept_i (accept_i),
    .load_i   (load_i),
    .trial_o  (trial_o),
    .result_o (result_o),
    .done_o   (done_o),
    .acc_q    (acc_q),
    .mask_q   (mask_q)
);

// File: tb/sar_datapath_tb.sv
module sar_datapath_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         shift_i = 1'b0;
    logic         accept_i = 1'b0;
    logic         load_i = 1'b0;
    logic [W-1:0] trial_o;
    logic [W-1:0] result_o;
    logic         done_o;

    int checks = 0;
    int errors = 0;
    int m_acc;
    int m_mask;
    int m_res;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sar_datapath #(.WIDTH(W)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_i  (shift_i),
        .accept_i (accept_i),
        .load_i   (load_i),
        .trial_o  (trial_o),
        .result_o (result_o),
        .done_o   (done_o)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive strobes at a falling edge, update model at rising edge, compare at next falling edge.
    task automatic cycle(bit s, bit a, bit l);
        shift_i  = s;
        accept_i = a;
        load_i   = l;
        @(posedge clk);
        if (l) begin
            m_res  = m_acc;
            m_acc  = 0;
            m_mask = 1 << (W-1);
        end else begin
            if (a) m_acc = m_acc | m_mask;
            if (s) m_mask = m_mask >> 1;
        end
        @(negedge clk);
        check("R2 trial", int'(trial_o), m_acc | m_mask);
        check("R6 done", int'(done_o), int'(m_mask == 0));
        check("R8 result", int'(result_o), m_res);
    endtask

    initial begin
        m_acc  = 0;
        m_mask = 1 << (W-1);
        m_res  = 0;
        repeat (2) @(negedge clk);
        check("R1 trial in reset", int'(trial_o), 8);
        check("R1 result in reset", int'(result_o), 0);
        check("R1 done in reset", int'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        cycle(0, 0, 0);
        check("R4 idle hold", int'(trial_o), 8);
        cycle(0, 1, 0);
        check("R4 accept alone", int'(trial_o), 8);
        cycle(1, 0, 0);
        check("R3 shift alone", int'(trial_o), 12);
        cycle(1, 1, 0);
        check("R5 shift with accept", int'(trial_o), 14);
        cycle(1, 0, 0);
        check("R4 drop bit", int'(trial_o), 13);
        cycle(1, 0, 0);
        check("R3 mask exhausted", int'(trial_o), 12);
        check("R6 done after width shifts", int'(done_o), 1);
        cycle(1, 1, 0);
        check("R3 shift past end", int'(trial_o), 12);
        check("R6 done stays", int'(done_o), 1);
        cycle(1, 1, 1);
        check("R7 load result", int'(result_o), 12);
        check("R7 load re-arm priority", int'(trial_o), 8);
        check("R7 done cleared", int'(done_o), 0);
        cycle(0, 0, 0);
        cycle(1, 1, 0);
        check("R8 result held", int'(result_o), 12);
        cycle(0, 0, 1);

        for (int code = 0; code < (1 << W); code++) begin
            for (int i = 0; i < W; i++) begin
                cycle(1'b1, int'(trial_o) <= code, 1'b0);
            end
            check("R6 done at end of conversion", int'(done_o), 1);
            cycle(0, 0, 1);
            check("R9 converted code", int'(result_o), code);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule